// File: doc/BRIEF.md
# Legacy Region Attribute Router

This block decides where each memory access in the legacy window from 768 KB up to 1 MB goes. The access either goes to main memory (DRAM) or is forwarded down to the I/O interface. The window is cut into thirteen segments:

- twelve segments of 16 KB each, covering 0C0000h to 0EFFFFh;
- one 64 KB segment covering 0F0000h to 0FFFFFh.

Every segment carries two attribute bits: one that lets reads go to DRAM and one that lets writes go to DRAM. An access whose direction is disabled is sent downstream at the same address. It is never moved to another DRAM location.

Two cases ignore the attributes or are flagged instead:

- A non-snooped access from an I/O requester always goes to DRAM, whatever the attributes say.
- An implicit-writeback cycle that would end up downstream cannot be serviced. It is flagged as an error on the response, and the error is also kept in a sticky status bit.

Software programs the attribute bits through a small register port and reads them back there. The request is decoded in the same cycle it is presented, and the decision appears on registered outputs one cycle later.

Top module: `lar_router`

## Requirements
- R1: Addresses from 0C0000h to 0FFFFFh are in the window. For these, rsp_in_window is 1. Segment index = (address − 0C0000h) / 16 KB for 0C0000h–0EFFFFh (indexes 0 to 11). The whole range 0F0000h–0FFFFFh is segment 12.
- R2: An address outside the window gives rsp_to_dram=1, rsp_in_window=0 and rsp_iwb_err=0, whatever the attributes, requester or writeback flag.
- R3: A read (req_write=0) is routed by the segment's read-enable bit, which is cfg_wdata/cfg_rdata bit 0. A write (req_write=1) is routed by its write-enable bit, which is bit 1. The two bits act independently.
- R4: When the enable for the access direction is 0, the access is routed downstream (rsp_to_dram=0). When it is 1, the access goes to DRAM (rsp_to_dram=1).
- R5: An in-window access with req_snoop=0 from a requester code other than 0 goes to DRAM regardless of the attributes. Code 0 is the processor, 1 is PCI Express and 2 is the downstream interface. A processor access, or any snooped access, follows the attributes.
- R6: An in-window access with req_iwb=1 that is routed downstream returns rsp_iwb_err=1 and sets err_flag. If the same access is routed to DRAM, no error is raised.
- R7: err_flag stays set until software writes 1 to bit 0 of config index 13. Writing 0 there has no effect. When a new error and a clear arrive in the same cycle, the error wins.
- R8: After reset, all 26 attribute bits are 0, err_flag is 0 and rsp_valid is 0. An access to the 64 KB top segment therefore goes downstream.
- R9: cfg_rdata shows, one cycle after cfg_addr is presented, {write-enable, read-enable} for indexes 0 to 12, {0, err_flag} for index 13, and 0 for any other index.
- R10: rsp_valid and the routing outputs follow req_valid by exactly one cycle. An attribute write at one clock edge does not affect a request sampled at that same edge, but it does affect requests sampled at every later edge.
- R11: The attribute pair of segment 12 controls the whole 64 KB top range. Writing a segment's attributes changes the routing of that segment only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 2 | Requester: 0 processor, 1 PCI Express, 2 downstream, 3 other I/O |
| req_snoop | input | 1 | Access is snooped |
| req_iwb | input | 1 | Access carries an implicit writeback |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | IDX_W | Config index: 0–12 segments, 13 status |
| cfg_wdata | input | 2 | Config write data |
| cfg_rdata | output | 2 | Registered config read data |
| rsp_valid | output | 1 | Decision valid, one cycle after req_valid |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = downstream |
| rsp_in_window | output | 1 | Access fell in the legacy window |
| rsp_iwb_err | output | 1 | Implicit writeback routed downstream |
| err_flag | output | 1 | Sticky error, cleared by writing 1 to status bit 0 |

## Verification
Every routing result is due on the clock edge that samples the request. The bench holds the request from one falling edge to the next, then samples the response at that second falling edge, one full register stage later. Config read data follows the same single-stage rule relative to cfg_addr. The error flag is read at the same point as the response that raised it. Same-edge cases are driven together within one low phase, so the old-value and set-wins outcomes are observed exactly one cycle later: an attribute write racing a request, and an error racing a clear.

// File: rtl/lar_pkg.sv
package lar_pkg;
  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_PCIE  = 2'd1,
    SRC_DOWN  = 2'd2,
    SRC_OTHER = 2'd3
  } lar_src_e;

  localparam int CFG_RD_BIT   = 0;
  localparam int CFG_WR_BIT   = 1;
  localparam int STAT_ERR_BIT = 0;
  localparam int CFG_DW       = 2;
endpackage

// File: rtl/lar_seg_decode.sv
module lar_seg_decode #(
  parameter int ADDR_W     = 32,
  parameter int WIN_BASE   = 32'h000C_0000,
  parameter int N_SMALL    = 12,
  parameter int SMALL_LOG2 = 14,
  parameter int TOP_LOG2   = 16,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx
);
  localparam longint BASE_L = longint'(WIN_BASE);
  localparam longint TOP_L  = BASE_L + (longint'(N_SMALL) << SMALL_LOG2);
  localparam longint END_L  = TOP_L + (longint'(1) << TOP_LOG2);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_L);
  localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(TOP_L);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(END_L);

  logic [ADDR_W-1:0] off;
  logic              hit_small;
  logic              hit_top;

  always_comb begin
    off       = addr - BASE_A;
    hit_small = (addr >= BASE_A) && (addr < TOP_A);
    hit_top   = (addr >= TOP_A) && (addr < END_A);
    in_win    = hit_small | hit_top;
    if (hit_top)
      idx = IDX_W'(N_SMALL);
    else if (hit_small)
      idx = IDX_W'(off >> SMALL_LOG2);
    else
      idx = '0;
  end
endmodule

// File: rtl/lar_attr_regs.sv
module lar_attr_regs
  import lar_pkg::*;
#(
  parameter int N_SEG = 13,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              err_in,
  output logic [N_SEG-1:0]  rd_en,
  output logic [N_SEG-1:0]  wr_en,
  output logic [CFG_DW-1:0] cfg_rdata
);
  localparam int STAT_IDX = N_SEG;

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_en[g] <= 1'b0;
        wr_en[g] <= 1'b0;
      end else if (cfg_we && (cfg_addr == IDX_W'(g))) begin
        rd_en[g] <= cfg_wdata[CFG_RD_BIT];
        wr_en[g] <= cfg_wdata[CFG_WR_BIT];
      end
    end
  end

  logic [CFG_DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (int'(cfg_addr) < N_SEG) begin
      rd_mux[CFG_RD_BIT] = rd_en[cfg_addr];
      rd_mux[CFG_WR_BIT] = wr_en[cfg_addr];
    end else if (int'(cfg_addr) == STAT_IDX) begin
      rd_mux[STAT_ERR_BIT] = err_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lar_route.sv
module lar_route
  import lar_pkg::*;
#(
  parameter int N_SEG = 13,
  parameter int IDX_W = 4
) (
  input  logic             in_win,
  input  logic [IDX_W-1:0] idx,
  input  logic [N_SEG-1:0] rd_en,
  input  logic [N_SEG-1:0] wr_en,
  input  logic             is_write,
  input  lar_src_e         src,
  input  logic             snoop,
  input  logic             iwb,
  output logic             to_dram,
  output logic             iwb_err
);
  logic io_bypass;
  logic dir_en;

  always_comb begin
    io_bypass = (src != SRC_CPU) && !snoop;
    dir_en    = 1'b0;
    if (int'(idx) < N_SEG)
      dir_en = is_write ? wr_en[idx] : rd_en[idx];
    if (!in_win)
      to_dram = 1'b1;
    else if (io_bypass)
      to_dram = 1'b1;
    else
      to_dram = dir_en;
    iwb_err = in_win && iwb && !to_dram;
  end
endmodule

// File: rtl/lar_router.sv
module lar_router
  import lar_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_BASE   = 32'h000C_0000,
  parameter int N_SMALL    = 12,
  parameter int SMALL_LOG2 = 14,
  parameter int TOP_LOG2   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_write,
  input  logic [1:0]                    req_src,
  input  logic                          req_snoop,
  input  logic                          req_iwb,
  input  logic                          cfg_we,
  input  logic [$clog2(N_SMALL+2)-1:0]  cfg_addr,
  input  logic [1:0]                    cfg_wdata,
  output logic [1:0]                    cfg_rdata,
  output logic                          rsp_valid,
  output logic                          rsp_to_dram,
  output logic                          rsp_in_window,
  output logic                          rsp_iwb_err,
  output logic                          err_flag
);
  localparam int N_SEG    = N_SMALL + 1;
  localparam int IDX_W    = $clog2(N_SMALL + 2);
  localparam int STAT_IDX = N_SEG;

  logic             dec_in_win;
  logic [IDX_W-1:0] dec_idx;
  logic [N_SEG-1:0] rd_en;
  logic [N_SEG-1:0] wr_en;
  logic             rt_to_dram;
  logic             rt_iwb_err;
  logic             err_new;
  logic             err_clr;

  lar_seg_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .N_SMALL(N_SMALL),
    .SMALL_LOG2(SMALL_LOG2), .TOP_LOG2(TOP_LOG2), .IDX_W(IDX_W)
  ) u_dec (
    .addr   (req_addr),
    .in_win (dec_in_win),
    .idx    (dec_idx)
  );

  lar_attr_regs #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .err_in    (err_flag),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .cfg_rdata (cfg_rdata)
  );

  lar_route #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_route (
    .in_win   (dec_in_win),
    .idx      (dec_idx),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .is_write (req_write),
    .src      (lar_src_e'(req_src)),
    .snoop    (req_snoop),
    .iwb      (req_iwb),
    .to_dram  (rt_to_dram),
    .iwb_err  (rt_iwb_err)
  );

  assign err_new = req_valid && rt_iwb_err;
  assign err_clr = cfg_we && (int'(cfg_addr) == STAT_IDX) && cfg_wdata[STAT_ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_to_dram   <= 1'b0;
      rsp_in_window <= 1'b0;
      rsp_iwb_err   <= 1'b0;
      err_flag      <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_to_dram   <= rt_to_dram;
        rsp_in_window <= dec_in_win;
        rsp_iwb_err   <= rt_iwb_err;
      end else begin
        rsp_iwb_err   <= 1'b0;
      end
      if (err_new)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lar_router_chk.sv
module lar_router_chk #(
  parameter int ADDR_W     = 32,
  parameter int WIN_BASE   = 32'h000C_0000,
  parameter int N_SMALL    = 12,
  parameter int SMALL_LOG2 = 14,
  parameter int TOP_LOG2   = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [ADDR_W-1:0]            req_addr,
  input logic [1:0]                   req_src,
  input logic                         req_snoop,
  input logic                         cfg_we,
  input logic [$clog2(N_SMALL+2)-1:0] cfg_addr,
  input logic [1:0]                   cfg_wdata,
  input logic                         rsp_valid,
  input logic                         rsp_to_dram,
  input logic                         rsp_in_window,
  input logic                         rsp_iwb_err,
  input logic                         err_flag
);
  localparam longint LO_L = longint'(WIN_BASE);
  localparam longint HI_L = LO_L + (longint'(N_SMALL) << SMALL_LOG2) + (longint'(1) << TOP_LOG2);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_L);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_L);

  logic in_range;
  logic clr_hit;
  assign in_range = (req_addr >= LO_A) && (req_addr < HI_A);
  assign clr_hit  = cfg_we && (int'(cfg_addr) == N_SMALL + 1) && cfg_wdata[0];

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_outside_dram_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_range) |=> (rsp_to_dram && !rsp_in_window && !rsp_iwb_err));
  p_window_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_range) |=> rsp_in_window);
  p_io_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_range && req_src != 2'd0 && !req_snoop) |=> rsp_to_dram);
  p_iwb_downstream_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_iwb_err |-> (!rsp_to_dram && rsp_in_window && err_flag));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr_hit) |=> err_flag);
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> rsp_iwb_err);
endmodule

bind lar_router lar_router_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .N_SMALL(N_SMALL),
  .SMALL_LOG2(SMALL_LOG2), .TOP_LOG2(TOP_LOG2)
) u_chk (.*);

// File: tb/test_lar_router.sv
module test_lar_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_snoop, req_iwb;
  logic [31:0] req_addr;
  logic [1:0]  req_src;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [1:0]  cfg_wdata;
  logic [1:0]  cfg_rdata;
  logic        rsp_valid, rsp_to_dram, rsp_in_window, rsp_iwb_err, err_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lar_router i_lar_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_src(req_src), .req_snoop(req_snoop),
    .req_iwb(req_iwb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
    .rsp_to_dram(rsp_to_dram), .rsp_in_window(rsp_in_window),
    .rsp_iwb_err(rsp_iwb_err), .err_flag(err_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int idx, output logic [1:0] d);
    @(negedge clk);
    cfg_addr = 4'(idx);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [1:0] s,
                        input logic sn, input logic iw);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_src = s;
    req_snoop = sn; req_iwb = iw;
    @(negedge clk);
    req_valid = 1'b0; req_iwb = 1'b0;
  endtask

  // expected packing: {valid, in_window, to_dram, iwb_err}
  task automatic expect_rsp(input string tag, input logic inw, input logic dram, input logic err);
    check(tag, {rsp_valid, rsp_in_window, rsp_to_dram, rsp_iwb_err}, {1'b1, inw, dram, err});
  endtask

  task automatic t_reset;
    logic [1:0] d;
    check("R8 rsp_valid after reset", rsp_valid, 0);
    check("R8 err_flag after reset", err_flag, 0);
    for (int i = 0; i < 14; i++) begin
      cfg_read(i, d);
      check($sformatf("R8 R9 reset readback idx %0d", i), d, 0);
    end
    access(32'h000F_8000, 1'b0, 2'd0, 1'b1, 1'b0);
    expect_rsp("R8 top segment read downstream", 1, 0, 0);
    access(32'h000F_8000, 1'b1, 2'd0, 1'b1, 1'b0);
    expect_rsp("R8 top segment write downstream", 1, 0, 0);
  endtask

  task automatic t_decode;
    cfg_write(5, 2'b01);
    access(32'h000D_4000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R1 seg5 low edge", 1, 1, 0);
    access(32'h000D_7FFF, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R1 seg5 high edge", 1, 1, 0);
    access(32'h000D_3FFF, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R11 seg4 untouched", 1, 0, 0);
    access(32'h000D_8000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R11 seg6 untouched", 1, 0, 0);
    access(32'h000C_0000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R1 window start seg0", 1, 0, 0);
    cfg_write(12, 2'b01);
    access(32'h000F_0000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R11 top seg start", 1, 1, 0);
    access(32'h000F_FFFF, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R11 top seg end", 1, 1, 0);
    access(32'h000E_FFFF, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R1 seg11 below top", 1, 0, 0);
    cfg_write(5, 2'b00);
    cfg_write(12, 2'b00);
  endtask

  task automatic t_outside;
    access(32'h000B_FFFF, 1'b0, 2'd0, 1'b1, 1'b1); expect_rsp("R2 below window", 0, 1, 0);
    access(32'h0010_0000, 1'b1, 2'd0, 1'b1, 1'b1); expect_rsp("R2 above window", 0, 1, 0);
    check("R2 no error flag", err_flag, 0);
  endtask

  task automatic t_direction;
    logic [1:0] d;
    cfg_write(0, 2'b10);
    cfg_read(0, d); check("R9 readback write-only", d, 2'b10);
    access(32'h000C_1000, 1'b1, 2'd0, 1'b1, 1'b0); expect_rsp("R3 R4 write enabled", 1, 1, 0);
    access(32'h000C_1000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R3 R4 read disabled", 1, 0, 0);
    cfg_write(0, 2'b01);
    access(32'h000C_1000, 1'b1, 2'd0, 1'b1, 1'b0); expect_rsp("R3 R4 write disabled", 1, 0, 0);
    access(32'h000C_1000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R3 R4 read enabled", 1, 1, 0);
    cfg_write(0, 2'b00);
    cfg_read(14, d); check("R9 unused index reads 0", d, 0);
  endtask

  task automatic t_nonsnoop;
    access(32'h000C_8000, 1'b0, 2'd1, 1'b0, 1'b0); expect_rsp("R5 pcie nonsnooped", 1, 1, 0);
    access(32'h000C_8000, 1'b1, 2'd2, 1'b0, 1'b0); expect_rsp("R5 downstream nonsnooped", 1, 1, 0);
    access(32'h000C_8000, 1'b0, 2'd0, 1'b0, 1'b0); expect_rsp("R5 cpu nonsnooped obeys", 1, 0, 0);
    access(32'h000C_8000, 1'b0, 2'd1, 1'b1, 1'b0); expect_rsp("R5 pcie snooped obeys", 1, 0, 0);
  endtask

  task automatic t_iwb;
    logic [1:0] d;
    access(32'h000E_4000, 1'b0, 2'd2, 1'b1, 1'b1); expect_rsp("R6 iwb downstream", 1, 0, 1);
    check("R6 err set", err_flag, 1);
    access(32'h000E_4000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R7 next resp clean", 1, 0, 0);
    check("R7 err sticky", err_flag, 1);
    cfg_read(13, d); check("R9 status readback", d, 2'b01);
    cfg_write(13, 2'b00); check("R7 write 0 keeps err", err_flag, 1);
    cfg_write(13, 2'b01); check("R7 write 1 clears", err_flag, 0);
    cfg_write(9, 2'b01);
    access(32'h000E_4000, 1'b0, 2'd0, 1'b1, 1'b1); expect_rsp("R6 iwb to dram ok", 1, 1, 0);
    check("R6 no err when dram", err_flag, 0);
    cfg_write(9, 2'b00);
    // error and clear on the same edge: error wins
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h000E_4000; req_write = 1'b0; req_src = 2'd0;
    req_snoop = 1'b1; req_iwb = 1'b1;
    cfg_we = 1'b1; cfg_addr = 4'd13; cfg_wdata = 2'b01;
    @(negedge clk);
    req_valid = 1'b0; req_iwb = 1'b0; cfg_we = 1'b0;
    check("R7 set wins over clear", err_flag, 1);
    cfg_write(13, 2'b01);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 2'b01;
    req_valid = 1'b1; req_addr = 32'h000D_C000; req_write = 1'b0; req_src = 2'd0;
    req_snoop = 1'b1; req_iwb = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R10 same-edge write uses old attr", 1, 0, 0);
    @(negedge clk);
    check("R10 valid drops after one cycle", rsp_valid, 0);
    access(32'h000D_C000, 1'b0, 2'd0, 1'b1, 1'b0); expect_rsp("R10 next access uses new attr", 1, 1, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_addr = 0; req_write = 0; req_src = 0;
    req_snoop = 1; req_iwb = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_outside();
    t_direction();
    t_nonsnoop();
    t_iwb();
    t_timing();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule